// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port that gives an external host read and write access to a register space. It runs entirely in the system clock domain. It oversamples the serial clock, the active-low select and the serial data input through synchronizer flops, and it acts on the edges it finds in the synchronized copies. A host cycle starts when select falls. The first sixteen serial-clock rising edges carry an instruction word. Data bytes follow, captured on rising edges for writes and driven on falling edges for reads. Each received write byte leaves the block as a one-cycle strobe with its address and value toward a shadow register buffer. Read bytes are fetched from that buffer through an address output and a combinational data input.

The instruction word is laid out as follows, and the same layout holds whichever bit order is used:

- Bit 15 selects the direction (1 = read, 0 = write).
- Bits 14:13 hold the length code (00 = one byte, 01 = two, 10 = three, 11 = open-ended streaming).
- Bits 12:0 hold the starting register address.

The host may raise select between bytes of a fixed-length cycle to stall the port, and lower it again later to continue. A rise of select partway through a byte cancels the cycle. A configuration input picks the bit order. A second one routes read data either to the shared data pin, through its output enable, or to a dedicated output for 4-wire hosts.

Top module: `spi_reg_port`

## Requirements
- R1: The first 16 serial-clock rising edges after select falls form the instruction word. Bit 15 = 1 means read and 0 means write, bits 14:13 are the length code, and bits 12:0 are the start address.
- R2: Each completed write data byte produces exactly one single-cycle `wrStrobe` carrying the byte's register address on `wrAddr` and its value on `wrData`.
- R3: After each data byte, the address steps by one: down when `lsbFirst` = 0 and up when `lsbFirst` = 1. It wraps modulo 2^13.
- R4: With `lsbFirst` = 0, every byte (both instruction bytes, high byte first, and each data byte) travels most significant bit first. With `lsbFirst` = 1, the instruction low byte goes first and every byte travels least significant bit first.
- R5: Length codes 00, 01 and 10 transfer exactly 1, 2 or 3 data bytes. Further serial clocks before select rises produce no strobe.
- R6: Length code 11 transfers data bytes, with the address stepping, until select rises on a byte boundary.
- R7: In a fixed-length cycle, select may rise on any byte boundary of the instruction or data phase. The cycle continues with the next byte when select falls again.
- R8: A select rise that is not on a byte boundary ends the cycle. This also covers 1 to 7 clocks given after a stall. The partial byte is dropped with no strobe, and the next select fall starts a new instruction.
- R9: In a read, `rdAddr` presents each byte's address. The byte read from `rdData` is shifted out on the falling edges, starting with the falling edge that follows the 16th instruction rising edge, in the bit order of R4.
- R10: In a read data phase, `fourWire` = 0 raises `sdioOe` and keeps `sdoOe` low. `fourWire` = 1 does the reverse.
- R11: Both output enables are low out of reset, during the instruction phase, during write cycles and once select has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the host |
| csNIn | input | 1 | Active-low select from the host |
| sdioIn | input | 1 | Serial data from the host (input side of the shared pin) |
| lsbFirst | input | 1 | Bit order: 0 = MSB first with decrementing address, 1 = LSB first with incrementing address |
| fourWire | input | 1 | 0 = read data on the shared pin, 1 = read data on the dedicated output |
| rdData | input | 8 | Read byte from the register buffer for `rdAddr` |
| rdAddr | output | 13 | Current register address |
| wrStrobe | output | 1 | One-cycle write strobe |
| wrAddr | output | 13 | Address of the strobed write |
| wrData | output | 8 | Data of the strobed write |
| sdioOut | output | 1 | Read data toward the shared pin |
| sdioOe | output | 1 | Output enable of the shared pin |
| sdoOut | output | 1 | Read data toward the dedicated output |
| sdoOe | output | 1 | Output enable of the dedicated output |

## Verification
The in-line properties watch, on every cycle, these local rules: write strobes last one cycle, each address step goes by exactly one in the configured direction, a stall holds until select falls, a mid-byte select rise lands in idle, a finished fixed cycle stays quiet, and the enables drop after select rises. Only the bench's host sequences can show the rest. These are the bit ordering, the instruction decode, the byte values and addresses on the strobes, the read data seen at the pins, the stall-and-resume and abort sequences, and address wrap across both ends of the space.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int ADDR_W  = 13;
  localparam int BYTE_W  = 8;
  localparam int INSTR_W = 16;
  localparam int LEN_W   = 2;
  localparam int BIT_W   = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_PAUSED,
    ST_DONE
  } portState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic latchInstr;
    logic emitWr;
    logic stepAddr;
    logic loadOut;
    logic shiftOut;
  } dpCtrl_t;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic sdiIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csRise,
  output logic csFall,
  output logic csNSync,
  output logic sdiSync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sclkPipe, csPipe, sdiPipe;
  logic sclkLast, csLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      sdiPipe  <= '0;
      sclkLast <= 1'b0;
      csLast   <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[LAST-1:0], sclkIn};
      csPipe   <= {csPipe[LAST-1:0], csNIn};
      sdiPipe  <= {sdiPipe[LAST-1:0], sdiIn};
      sclkLast <= sclkPipe[LAST];
      csLast   <= csPipe[LAST];
    end
  end

  assign sclkRise = sclkPipe[LAST] & ~sclkLast;
  assign sclkFall = ~sclkPipe[LAST] & sclkLast;
  assign csRise   = csPipe[LAST] & ~csLast;
  assign csFall   = ~csPipe[LAST] & csLast;
  assign csNSync  = csPipe[LAST];
  assign sdiSync  = sdiPipe[LAST];
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclkRise,
  input  logic                 sclkFall,
  input  logic                 csRise,
  input  logic                 csFall,
  input  logic                 csNSync,
  input  logic                 fourWire,
  input  logic [INSTR_W-1:0]   wordNext,
  output dpCtrl_t              ctl,
  output logic                 sdioOe,
  output logic                 sdoOe
);
  portState_t       state;
  logic [BIT_W-1:0] bitCnt;
  logic             instrHi, inData, isRead, streaming, rdLoadPend;
  logic [LEN_W-1:0] bytesLeft;
  logic             byteEnd, readDrive;

  assign byteEnd = (bitCnt == BIT_W'(BYTE_W - 1));

  always_comb begin
    ctl = '0;
    ctl.loadOut = rdLoadPend;
    if (state == ST_ACTIVE && sclkRise && !csRise) begin
      ctl.shiftIn = 1'b1;
      if (byteEnd) begin
        ctl.latchInstr = !inData && instrHi;
        ctl.stepAddr   = inData;
        ctl.emitWr     = inData && !isRead;
      end
    end
    ctl.shiftOut = (state == ST_ACTIVE) && inData && isRead && sclkFall;
  end

  assign readDrive = (state == ST_ACTIVE || state == ST_DONE) && inData && isRead && !csNSync;
  assign sdioOe    = readDrive && !fourWire;
  assign sdoOe     = readDrive && fourWire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      instrHi    <= 1'b0;
      inData     <= 1'b0;
      isRead     <= 1'b0;
      streaming  <= 1'b0;
      bytesLeft  <= '0;
      rdLoadPend <= 1'b0;
    end else begin
      rdLoadPend <= 1'b0;
      unique case (state)
        ST_IDLE: if (csFall) begin
          state     <= ST_ACTIVE;
          bitCnt    <= '0;
          instrHi   <= 1'b0;
          inData    <= 1'b0;
          isRead    <= 1'b0;
          streaming <= 1'b0;
          bytesLeft <= '0;
        end
        ST_ACTIVE: begin
          if (csRise) begin
            if (bitCnt != '0 || (!inData && !instrHi) || (inData && streaming))
              state <= ST_IDLE;
            else
              state <= ST_PAUSED;
          end else if (sclkRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (byteEnd) begin
              if (!inData) begin
                if (!instrHi) instrHi <= 1'b1;
                else begin
                  inData     <= 1'b1;
                  isRead     <= wordNext[INSTR_W-1];
                  streaming  <= &wordNext[ADDR_W+LEN_W-1:ADDR_W];
                  bytesLeft  <= wordNext[ADDR_W+LEN_W-1:ADDR_W];
                  rdLoadPend <= wordNext[INSTR_W-1];
                end
              end else if (streaming) begin
                rdLoadPend <= isRead;
              end else if (bytesLeft == '0) begin
                state <= ST_DONE;
              end else begin
                bytesLeft  <= bytesLeft - 1'b1;
                rdLoadPend <= isRead;
              end
            end
          end
        end
        ST_PAUSED: if (csFall) state <= ST_ACTIVE;
        ST_DONE:   if (csRise) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && csRise && bitCnt != '0) |=> (state == ST_IDLE));

  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSED && !csFall) |=> (state == ST_PAUSED && bitCnt == '0));

  // R5
  done_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_DONE || state == ST_IDLE));

  // R11
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> !(sdioOe || sdoOe));
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctl,
  input  logic                 sdiSync,
  input  logic                 lsbFirst,
  input  logic [BYTE_W-1:0]    rdData,
  output logic [INSTR_W-1:0]   wordNext,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic                 wrStrobe,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [BYTE_W-1:0]    wrData,
  output logic                 dataOut
);
  logic [INSTR_W-1:0] inSr;
  logic [BYTE_W-1:0]  outSr, byteNext;
  logic [ADDR_W-1:0]  addr;

  assign wordNext = lsbFirst ? {sdiSync, inSr[INSTR_W-1:1]} : {inSr[INSTR_W-2:0], sdiSync};
  assign byteNext = lsbFirst ? wordNext[INSTR_W-1:INSTR_W-BYTE_W] : wordNext[BYTE_W-1:0];
  assign rdAddr   = addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSr     <= '0;
      outSr    <= '0;
      addr     <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      dataOut  <= 1'b0;
    end else begin
      wrStrobe <= 1'b0;
      if (ctl.shiftIn) inSr <= wordNext;
      if (ctl.emitWr) begin
        wrStrobe <= 1'b1;
        wrAddr   <= addr;
        wrData   <= byteNext;
      end
      if (ctl.latchInstr)
        addr <= wordNext[ADDR_W-1:0];
      else if (ctl.stepAddr)
        addr <= lsbFirst ? addr + ADDR_W'(1) : addr - ADDR_W'(1);
      if (ctl.loadOut) begin
        outSr <= rdData;
      end else if (ctl.shiftOut) begin
        dataOut <= lsbFirst ? outSr[0] : outSr[BYTE_W-1];
        outSr   <= lsbFirst ? {1'b0, outSr[BYTE_W-1:1]} : {outSr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepAddr && !ctl.latchInstr) |=>
      (addr == ($past(lsbFirst) ? $past(addr) + ADDR_W'(1) : $past(addr) - ADDR_W'(1))));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              sdioIn,
  input  logic              lsbFirst,
  input  logic              fourWire,
  input  logic [BYTE_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              sdioOut,
  output logic              sdioOe,
  output logic              sdoOut,
  output logic              sdoOe
);
  logic sclkRise, sclkFall, csRise, csFall, csNSync, sdiSync, dataOut;
  logic [INSTR_W-1:0] wordNext;
  dpCtrl_t ctl;

  spi_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .sdiIn(sdioIn),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csRise(csRise), .csFall(csFall),
    .csNSync(csNSync), .sdiSync(sdiSync)
  );

  spi_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csRise(csRise), .csFall(csFall), .csNSync(csNSync), .fourWire(fourWire),
    .wordNext(wordNext), .ctl(ctl), .sdioOe(sdioOe), .sdoOe(sdoOe)
  );

  spi_port_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdiSync(sdiSync), .lsbFirst(lsbFirst),
    .rdData(rdData), .wordNext(wordNext), .rdAddr(rdAddr), .wrStrobe(wrStrobe),
    .wrAddr(wrAddr), .wrData(wrData), .dataOut(dataOut)
  );

  assign sdioOut = dataOut;
  assign sdoOut  = dataOut;
endmodule

// File: tb/tb_spi_reg_port.sv
module tb_spi_reg_port;
  localparam int H = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, sclk, csN, sdi, lsb, fw;
  logic [7:0]  rdData;
  logic [12:0] rdAddr, wrAddr;
  logic [7:0]  wrData;
  logic wrStrobe, sdioOut, sdioOe, sdoOut, sdoOe;

  spi_reg_port dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN), .sdioIn(sdi),
    .lsbFirst(lsb), .fourWire(fw), .rdData(rdData), .rdAddr(rdAddr),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  function automatic logic [7:0] expRd(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [12:0] stepA(input logic [12:0] a, input int n, input logic l);
    return l ? a + 13'(n) : a - 13'(n);
  endfunction

  function automatic int effLen(input logic [1:0] len, input int nB);
    if (len == 2'b11) return nB;
    return (nB < int'(len) + 1) ? nB : int'(len) + 1;
  endfunction

  always_comb rdData = expRd(rdAddr);

  int checks = 0, errors = 0, oeBad = 0;
  logic [12:0] wrA [0:63];
  logic [7:0]  wrD [0:63];
  int wrCnt = 0;
  logic [7:0] txD [0:15];
  logic [7:0] rxD [0:15];

  always @(posedge clk) begin
    if (rstN && wrStrobe) begin
      if (wrCnt < 64) begin
        wrA[wrCnt] <= wrAddr;
        wrD[wrCnt] <= wrData;
      end
      wrCnt <= (wrCnt + 1) % 64;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clkBit(input logic b, input logic chkOe, input logic oeExp, output logic got);
    sdi = b;
    repeat (H) @(negedge clk);
    got = fw ? sdoOut : sdioOut;
    if (chkOe) begin
      if ((fw ? sdoOe : sdioOe) !== oeExp || (fw ? sdioOe : sdoOe) !== 1'b0) oeBad++;
    end
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xByte(input logic [7:0] v, input logic chkOe, input logic oeExp, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      logic g;
      int idx;
      idx = lsb ? i : 7 - i;
      clkBit(v[idx], chkOe, oeExp, g);
      got[idx] = g;
    end
  endtask

  task automatic csDown();
    csN = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic csUp();
    repeat (H) @(negedge clk);
    csN = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  // pauseMask bit 0: after instruction byte 0; bit 1: after instruction byte 1; bit k+2: after data byte k
  task automatic xfer(input logic rd, input logic [1:0] len, input logic [12:0] addr,
                      input int nB, input int pauseMask);
    logic [15:0] w;
    logic [7:0]  junk, b0, b1;
    int eff;
    eff = effLen(len, nB);
    w  = {rd, len, addr};
    b0 = lsb ? w[7:0] : w[15:8];
    b1 = lsb ? w[15:8] : w[7:0];
    oeBad = 0;
    csDown();
    xByte(b0, 1'b1, 1'b0, junk);
    if (pauseMask[0]) begin csUp(); csDown(); end
    xByte(b1, 1'b1, 1'b0, junk);
    if (pauseMask[1]) begin csUp(); csDown(); end
    for (int k = 0; k < nB; k++) begin
      logic [7:0] r;
      xByte(txD[k], k < eff, rd, r);
      rxD[k] = r;
      if (pauseMask[k + 2] && k < nB - 1) begin csUp(); csDown(); end
    end
    csUp();
  endtask

  task automatic verify(input logic rd, input logic [1:0] len, input logic [12:0] addr,
                        input int nB, input int base, input string tag);
    int eff, got;
    eff = effLen(len, nB);
    got = (wrCnt - base + 64) % 64;
    if (rd) begin
      check(got == 0, {tag, " R2 no strobe on read"}, got, 0);
      for (int i = 0; i < eff; i++)
        check(rxD[i] == expRd(stepA(addr, i, lsb)), {tag, " R9 read byte"},
              rxD[i], expRd(stepA(addr, i, lsb)));
    end else begin
      check(got == eff, {tag, " R5 strobe count"}, got, eff);
      for (int i = 0; i < eff && i < got; i++) begin
        check(wrA[(base + i) % 64] == stepA(addr, i, lsb), {tag, " R3 write address"},
              wrA[(base + i) % 64], stepA(addr, i, lsb));
        check(wrD[(base + i) % 64] == txD[i], {tag, " R2 write data"},
              wrD[(base + i) % 64], txD[i]);
      end
    end
    check(oeBad == 0, {tag, " R10 enables during cycle"}, oeBad, 0);
    check(!sdioOe && !sdoOe, {tag, " R11 enables after select high"}, {sdioOe, sdoOe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic g;
    logic [7:0] junk;
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0; lsb = 1'b0; fw = 1'b0;
    repeat (5) @(negedge clk);
    check(!sdioOe && !sdoOe, "R11 reset enables", {sdioOe, sdoOe}, 0);
    check(!wrStrobe, "R2 reset strobe", wrStrobe, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2: single MSB-first write
    base = wrCnt; txD[0] = 8'hA5;
    xfer(1'b0, 2'b00, 13'h0123, 1, 0);
    verify(1'b0, 2'b00, 13'h0123, 1, base, "R1 single write");

    // R4 R7 R3: LSB-first 3-byte write with stalls, wraps upward
    lsb = 1'b1; base = wrCnt;
    txD[0] = 8'h11; txD[1] = 8'h82; txD[2] = 8'hC3;
    xfer(1'b0, 2'b10, 13'h1FFE, 3, 32'b0101);
    verify(1'b0, 2'b10, 13'h1FFE, 3, base, "R4 R7 lsb stalled write");

    // R9 R10: 3-wire MSB-first 2-byte read
    lsb = 1'b0; fw = 1'b0; base = wrCnt;
    xfer(1'b1, 2'b01, 13'h0040, 2, 0);
    verify(1'b1, 2'b01, 13'h0040, 2, base, "R9 3-wire read");

    // R6 R10 R3: 4-wire LSB-first streaming read across top of space
    lsb = 1'b1; fw = 1'b1; base = wrCnt;
    xfer(1'b1, 2'b11, 13'h1FFD, 5, 0);
    verify(1'b1, 2'b11, 13'h1FFD, 5, base, "R6 4-wire stream read");

    // R6 R3: MSB-first streaming write wrapping downward
    lsb = 1'b0; fw = 1'b0; base = wrCnt;
    for (int i = 0; i < 4; i++) txD[i] = 8'(8'h30 + i);
    xfer(1'b0, 2'b11, 13'h0001, 4, 0);
    verify(1'b0, 2'b11, 13'h0001, 4, base, "R6 stream write");

    // R5: one-byte write followed by extra bytes
    base = wrCnt; txD[0] = 8'h5C; txD[1] = 8'hEE; txD[2] = 8'h77;
    xfer(1'b0, 2'b00, 13'h0A00, 3, 0);
    verify(1'b0, 2'b00, 13'h0A00, 3, base, "R5 extra bytes ignored");

    // R8: select rises three bits into a data byte
    base = wrCnt;
    csDown();
    xByte(8'h00, 1'b0, 1'b0, junk);   // write, length 1, address 0x0AA (MSB first)
    xByte(8'hAA, 1'b0, 1'b0, junk);
    for (int i = 0; i < 3; i++) clkBit(1'b1, 1'b0, 1'b0, g);
    csUp();
    check(wrCnt == base, "R8 mid-byte abort leaves no strobe", (wrCnt - base + 64) % 64, 0);
    txD[0] = 8'h3C;
    xfer(1'b0, 2'b00, 13'h00AB, 1, 0);
    verify(1'b0, 2'b00, 13'h00AB, 1, base, "R8 write after abort");

    // R8: stall after first instruction byte, then 3 clocks and release
    base = wrCnt;
    csDown();
    xByte(8'h01, 1'b0, 1'b0, junk);
    csUp();
    csDown();
    for (int i = 0; i < 3; i++) clkBit(1'b0, 1'b0, 1'b0, g);
    csUp();
    check(wrCnt == base, "R8 stall abort leaves no strobe", (wrCnt - base + 64) % 64, 0);
    txD[0] = 8'h81;
    xfer(1'b0, 2'b00, 13'h00F0, 1, 0);
    verify(1'b0, 2'b00, 13'h00F0, 1, base, "R8 fresh instruction after stall abort");

    // random cycles
    for (int t = 0; t < 24; t++) begin
      logic rd;
      logic [1:0] len;
      logic [12:0] addr;
      int nB, mask, allowed, eff;
      rd   = 1'($urandom % 2);
      len  = 2'($urandom % 4);
      addr = 13'($urandom);
      lsb  = 1'($urandom % 2);
      fw   = 1'($urandom % 2);
      nB   = (len == 2'b11) ? 1 + int'($urandom % 6) : int'(len) + 1 + int'($urandom % 2);
      eff  = effLen(len, nB);
      for (int i = 0; i < nB; i++) txD[i] = 8'($urandom);
      if (len == 2'b11) allowed = 1;
      else begin
        allowed = 3;
        for (int k = 0; k < eff - 1; k++) allowed |= (1 << (k + 2));
      end
      mask = int'($urandom) & allowed;
      base = wrCnt;
      xfer(rd, len, addr, nB, mask);
      verify(rd, len, addr, nB, base, "R1 R4 random cycle");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule